// File: doc/BRIEF.md
# Dual-Channel Start-Up Sequencing Arbiter

This block decides when each of two power channels may begin its start-up timing period. Each channel raises a level request line. In independent mode, the first request to arrive gets a start pulse at once and opens a shared timer period. A second request that arrives within a short merge window joins that same period. A request that arrives after the merge window is held back. It is released only after the shared timer has expired, a fixed settling delay has run out and, if enabled, the external timer has reported that it is back at its low state. In paired mode, both channels start together, and only once both are requesting.

All durations are parameters counted in clock cycles. At 50 MHz the defaults give a 10-cycle merge window and 100 ms periods. The timer is a plain cycle counter.

The controller has four states:
- `ST_IDLE`: no period is running. It moves to `ST_MERGE` when any start is granted.
- `ST_MERGE`: the coincidence window. It moves to `ST_RUN` when the counter reaches `WIN_CYC-1`.
- `ST_RUN`: the rest of the period. It moves to `ST_SETTLE` when the counter reaches `TMR_CYC-1`, and the counter restarts.
- `ST_SETTLE`: the post-expiry delay. It returns to `ST_IDLE` once the counter has reached `SET_CYC-1` and the idle condition holds.

Top module: `pwr_seq_arb`

## Requirements
- R1: While `rst` is sampled high, `ch_start` and `tmr_run` are 0 after the edge, and all request history is forgotten.
- R2: With no period running, an unserved request sampled at an edge gives a one-cycle pulse on that channel's `ch_start` bit after that edge. `tmr_run` rises in the same cycle and stays high for exactly `TMR_CYC` cycles.
- R3: In independent mode (`indep_mode`=1), a request sampled on any of the `WIN_CYC` edges that follow the first start edge is started at once, within the same period.
- R4: A request sampled later in the period, or during settling, is not started then. With `tmr_low` held at 1, its pulse appears `SET_CYC+1` cycles after `tmr_run` falls, and it opens a new period.
- R5: When `USE_IDLE`=1, settling cannot end while `tmr_low` is sampled 0. A deferred start then waits until `tmr_low` is sampled 1.
- R6: Dropping a request before its deferred start cancels that start, so no pulse is issued for it.
- R7: Each assertion of a request yields at most one pulse. A channel whose request stays high is never started again. To get a new start, the request must go low and then high again.
- R8: In paired mode (`indep_mode`=0), nothing starts until both channels are requesting and unserved. Both `ch_start` bits then pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req | input | NCH | Per-channel start request level (bit 0 = channel 0) |
| indep_mode | input | 1 | 1 = channels start independently, 0 = paired start |
| tmr_low | input | 1 | External timer reports its low state (used when USE_IDLE=1) |
| ch_start | output | NCH | One-cycle start pulse per channel |
| tmr_run | output | 1 | Shared start-up timer period in progress |

## Verification
A corrupted state or counter shows up at the ports within one period. A wrong merge length moves a second channel's pulse into, or out of, the first period. A wrong settle count or a missed idle check shifts the deferred pulse away from `SET_CYC+1` cycles after `tmr_run` falls. A stale served flag either repeats a pulse on a held request or suppresses one after re-assertion. A reference model of the request timing is stepped alongside the design and compared on every cycle, so any such slip shows up in the cycle where it first occurs.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MERGE  = 2'd1,
        ST_RUN    = 2'd2,
        ST_SETTLE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pwr_seq_cnt.sv
module pwr_seq_cnt #(
    parameter int MAXV = 100,
    localparam int CW = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (cnt != CW'(MAXV))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_seq_reqtrack.sv
module pwr_seq_reqtrack #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] grant,
    output logic [NCH-1:0] pend
);
    logic [NCH-1:0] served_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                served_q[g] <= 1'b0;
            else
                served_q[g] <= (served_q[g] & req[g]) | grant[g];
        end
        assign pend[g] = req[g] & ~served_q[g];
    end
endmodule

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb
    import pwr_seq_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int WIN_CYC  = 10,
    parameter int TMR_CYC  = 5_000_000,
    parameter int SET_CYC  = 5_000_000,
    parameter bit USE_IDLE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] on_req,
    input  logic           indep_mode,
    input  logic           tmr_low,
    output logic [NCH-1:0] ch_start,
    output logic           tmr_run
);
    localparam int MAXC = (TMR_CYC > SET_CYC) ? TMR_CYC : SET_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t     state, state_n;
    logic [CW-1:0]  cnt;
    logic           cnt_clr;
    logic [NCH-1:0] pend, sel, grant;
    logic           merge_end, run_end, settle_ok;

    pwr_seq_reqtrack #(.NCH(NCH)) i_track (
        .clk   (clk),
        .rst   (rst),
        .req   (on_req),
        .grant (grant),
        .pend  (pend)
    );

    pwr_seq_cnt #(.MAXV(MAXC)) i_cnt (
        .clk (clk),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    assign merge_end = (cnt == CW'(WIN_CYC - 1));
    assign run_end   = (cnt == CW'(TMR_CYC - 1));
    assign settle_ok = (cnt >= CW'(SET_CYC - 1)) && (!USE_IDLE || tmr_low);

    always_comb begin
        if (indep_mode)
            sel = pend;
        else
            sel = (&pend) ? '1 : '0;
        grant = (state == ST_IDLE || state == ST_MERGE) ? sel : '0;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (|grant)    state_n = ST_MERGE;
            ST_MERGE:  if (merge_end) state_n = ST_RUN;
            ST_RUN:    if (run_end)   state_n = ST_SETTLE;
            ST_SETTLE: if (settle_ok) state_n = ST_IDLE;
            default:                  state_n = ST_IDLE;
        endcase
    end

    assign cnt_clr = rst || (state == ST_IDLE) || (state == ST_RUN && run_end);

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_start <= '0;
            tmr_run  <= 1'b0;
        end else begin
            ch_start <= grant;
            tmr_run  <= (state_n == ST_MERGE) || (state_n == ST_RUN);
        end
    end

    a_r2_start_in_period: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> tmr_run);

    a_r2_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(tmr_run) |-> ($past(cnt) == CW'(TMR_CYC - 1)));

    a_r8_paired_start: assert property (@(posedge clk) disable iff (rst)
        ((|ch_start) && !$past(indep_mode)) |-> (&ch_start));

    a_r5_idle_gate: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_SETTLE) |-> (!USE_IDLE || $past(tmr_low)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
            ch_start[g] |=> !ch_start[g]);
        a_r6_start_needs_req: assert property (@(posedge clk) disable iff (rst)
            ch_start[g] |-> $past(on_req[g]));
    end
endmodule

// File: tb/test_pwr_seq_arb.sv
module test_pwr_seq_arb;
    localparam int W = 4;
    localparam int T = 20;
    localparam int S = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] on_req = 2'b00;
    logic       indep_mode = 1'b1;
    logic       tmr_low = 1'b1;
    logic [1:0] ch_start;
    logic       tmr_run;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pwr_seq_arb #(.NCH(2), .WIN_CYC(W), .TMR_CYC(T), .SET_CYC(S), .USE_IDLE(1'b1)) i_pwr_seq_arb (
        .clk        (clk),
        .rst        (rst),
        .on_req     (on_req),
        .indep_mode (indep_mode),
        .tmr_low    (tmr_low),
        .ch_start   (ch_start),
        .tmr_run    (tmr_run)
    );

    always #10 clk = ~clk;

    // behavioural reference: phase 0 idle, 1 window, 2 running, 3 settling
    int       m_phase = 0;
    int       m_age = 0;
    bit [1:0] m_used = 2'b00;
    bit [1:0] e_start = 2'b00;
    bit       e_run = 1'b0;
    int       cyc = 0;

    always @(posedge clk) begin
        bit [1:0] want;
        bit [1:0] give;
        cyc++;
        if (rst) begin
            m_phase = 0; m_age = 0; m_used = 2'b00; e_start = 2'b00; e_run = 1'b0;
        end else begin
            want = 2'b00;
            for (int i = 0; i < 2; i++)
                if (on_req[i] && !m_used[i]) want[i] = 1'b1;
            if (indep_mode) give = want;
            else give = (want == 2'b11) ? 2'b11 : 2'b00;
            if (m_phase > 1) give = 2'b00;
            for (int i = 0; i < 2; i++)
                if (!on_req[i]) m_used[i] = 1'b0;
            m_used = m_used | give;
            e_start = give;
            if (m_phase == 0) begin
                if (give != 0) begin m_phase = 1; m_age = 0; end
            end else if (m_phase == 1) begin
                if (m_age == W - 1) m_phase = 2;
                m_age++;
            end else if (m_phase == 2) begin
                if (m_age == T - 1) begin m_phase = 3; m_age = 0; end
                else m_age++;
            end else begin
                if (m_age >= S - 1 && tmr_low) m_phase = 0;
                else m_age++;
            end
            e_run = (m_phase == 1 || m_phase == 2);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    int  s0 = 0, s1 = 0, s0_cyc = 0, s1_cyc = 0, fall_cyc = 0;
    bit  run_prev = 1'b0;

    always @(negedge clk) begin
        if (!done) begin
            chk(ch_start == e_start, "R2/R3/R4/R6/R8 per-cycle ch_start", ch_start, e_start);
            chk(tmr_run == e_run, "R2/R5 per-cycle tmr_run", tmr_run, e_run);
        end
        if (ch_start[0]) begin s0++; s0_cyc = cyc; end
        if (ch_start[1]) begin s1++; s1_cyc = cyc; end
        if (run_prev && !tmr_run && fall_cyc == 0) fall_cyc = cyc;
        run_prev = tmr_run;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clr_cnt();
        s0 = 0; s1 = 0; s0_cyc = 0; s1_cyc = 0; fall_cyc = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset with requests held high
        on_req = 2'b11;
        tick(3);
        chk(ch_start == 2'b00, "R1 start in reset", ch_start, 0);
        chk(tmr_run == 1'b0, "R1 run in reset", tmr_run, 0);
        on_req = 2'b00;
        tick(1);
        rst = 1'b0;
        tick(2);

        // R2 R3: second request inside merge window
        clr_cnt();
        on_req[0] = 1'b1;
        tick(2);
        on_req[1] = 1'b1;
        tick(30);
        chk(s0 == 1, "R2 first start", s0, 1);
        chk(s1 == 1, "R3 merged second start", s1, 1);
        chk(s1_cyc - s0_cyc == 2, "R3 merged start timing", s1_cyc - s0_cyc, 2);
        on_req = 2'b00;
        tick(20);

        // R4: late request deferred behind settle
        clr_cnt();
        on_req[0] = 1'b1;
        tick(8);
        on_req[1] = 1'b1;
        tick(60);
        chk(s1 == 1, "R4 deferred start issued", s1, 1);
        chk(s1_cyc - fall_cyc == S + 1, "R4 deferred delay", s1_cyc - fall_cyc, S + 1);
        on_req = 2'b00;
        tick(40);

        // R5: idle input low holds settle
        clr_cnt();
        tmr_low = 1'b0;
        on_req[0] = 1'b1;
        tick(8);
        on_req[1] = 1'b1;
        tick(50);
        chk(s1 == 0, "R5 held while timer not low", s1, 0);
        tmr_low = 1'b1;
        tick(20);
        chk(s1 == 1, "R5 released after timer low", s1, 1);
        on_req = 2'b00;
        tick(40);

        // R6: cancel pending start
        clr_cnt();
        on_req[0] = 1'b1;
        tick(8);
        on_req[1] = 1'b1;
        tick(6);
        on_req[1] = 1'b0;
        tick(50);
        chk(s1 == 0, "R6 cancelled start", s1, 0);
        chk(s0 == 1, "R6 first channel start", s0, 1);
        on_req = 2'b00;
        tick(40);

        // R7: held request gives one pulse; re-assertion gives another
        clr_cnt();
        on_req[0] = 1'b1;
        tick(80);
        chk(s0 == 1, "R7 single pulse while held", s0, 1);
        on_req[0] = 1'b0;
        tick(2);
        on_req[0] = 1'b1;
        tick(3);
        chk(s0 == 2, "R7 new pulse after re-assert", s0, 2);
        on_req = 2'b00;
        tick(40);

        // R8: paired mode
        indep_mode = 1'b0;
        clr_cnt();
        on_req[0] = 1'b1;
        tick(30);
        chk(s0 == 0, "R8 no start with one request", s0, 0);
        on_req[1] = 1'b1;
        tick(3);
        chk(s0 == 1 && s1 == 1, "R8 both started", s0 + s1, 2);
        chk(s0_cyc == s1_cyc, "R8 same-cycle pulses", s1_cyc - s0_cyc, 0);
        on_req = 2'b00;
        tick(40);

        finish_run();
    end
endmodule